// File: doc/BRIEF.md
# Paced ADC Conversion Sequencer

This block decides when a single 12-bit analogue-to-digital converter runs. It counts pulses from an external pacer timer and issues one conversion for every eight pacer ticks that reach it. In free-running mode every tick counts. In triggered mode ticks only count inside a window that a software start strobe opens; the window closes after eight ticks, and that closing starts one conversion. Ticks are blocked by a pacer-enable control bit and by an external start/stop pin.

The converter is driven through a start/busy/done handshake. When a result arrives it is held in a result register. An active-low ready flag falls, and a one-cycle interrupt request is raised. A read by the host releases the flag. When a result lands on top of an unread one, a sticky overrun bit is set, and a status read clears it. The channel number sent to the analogue multiplexer comes either from a software-written select field or, in auto-scan mode, from an internal pointer. Each host read of the result moves that pointer on to the next channel.

Top module: `paced_adc_sequencer`

## Requirements
- R1: With triggered mode off, pacer enable high and the external pin high, every eighth pacer tick since the counter was last cleared requests a conversion, with no ticks lost between results.
- R2: With triggered mode on (`cfg_sw_trig`=1) and no start strobe, pacer ticks are not counted and no conversion starts.
- R3: In triggered mode, `sw_start` opens a window that admits exactly eight pacer ticks, and the eighth requests one conversion and closes the window. A `sw_start` while the window is open has no effect.
- R4: While `cfg_pacer_en` is low, ticks are ignored and the tick counter is cleared, and the window is closed.
- R5: While `ext_enable` is low, ticks are ignored, but the tick counter keeps its value.
- R6: After a request, `adc_start` goes high the next cycle and stays high until `adc_busy` is sampled high. `adc_data` is captured into `result` in the cycle `adc_done` is seen. A request that comes while a conversion is in progress is dropped.
- R7: At reset `data_ready_n`=1, `irq`=0, `overrun`=0, `result`=0 and `adc_start`=0. A capture drives `data_ready_n` low and `irq` high for exactly the next cycle. A `rd_result` pulse returns `data_ready_n` to 1, unless a capture happens in the same cycle, in which case the capture wins.
- R8: A capture while `data_ready_n` is low and no `rd_result` is present sets `overrun`. It stays set until a `rd_status` pulse clears it, and a capture that sets it in the same cycle wins.
- R9: With `cfg_autoscan`=1, a `rd_result` while `data_ready_n` is low advances `chan` by one. Channel codes 0..7 stand for channels 1..8, and code 7 wraps to code 0.
- R10: With `cfg_autoscan`=0, `chan` equals `cfg_chan_sel`. The scan pointer follows that field, so when auto-scan is switched on, `chan` starts from the selected channel.
- R11: A change of `cfg_sw_trig` clears the tick counter and closes the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pacer_tick | input | 1 | One-cycle pulse from the pacer timer |
| sw_start | input | 1 | Software start strobe for triggered mode |
| ext_enable | input | 1 | External start/stop pin, high allows ticks |
| cfg_sw_trig | input | 1 | Control bit 0: 1 = triggered, 0 = free-running |
| cfg_autoscan | input | 1 | Control bit 1: 1 = auto-scan channels |
| cfg_pacer_en | input | 1 | Control bit 2: 1 = pacer ticks allowed |
| cfg_chan_sel | input | 3 | Manual channel code (0..7) |
| rd_result | input | 1 | Host read of the result, one cycle |
| rd_status | input | 1 | Host read of status, clears overrun |
| adc_busy | input | 1 | Converter busy |
| adc_done | input | 1 | Converter result valid, one cycle |
| adc_data | input | 12 | Converter result |
| adc_start | output | 1 | Conversion start request to the converter |
| chan | output | 3 | Current channel code to the multiplexer |
| result | output | 12 | Latched conversion result |
| data_ready_n | output | 1 | Active-low result-ready flag |
| irq | output | 1 | One-cycle interrupt request per result |
| overrun | output | 1 | Sticky flag: a result was overwritten unread |

## Verification
A tick counter that is off by one moves the `irq` pulses by a whole pacer period, and the shift shows up within the first eight ticks after the counter is cleared. A window that leaks or stays open shows up as extra pulses during a long run of triggered ticks. A wrong scan pointer appears on `chan` at the first host read. A wrong ready or overrun state is visible on the next capture or read. The reference model in the bench compares every output on every cycle, so any divergence is reported in the cycle it first appears at a port.

// File: rtl/pas_pkg.sv
package pas_pkg;

  typedef enum logic [1:0] {
    CV_IDLE  = 2'd0,
    CV_START = 2'd1,
    CV_WAIT  = 2'd2
  } conv_state_e;

  // modulo increment used by the tick counter and the channel pointer
  function automatic int unsigned next_index(input int unsigned cur,
                                             input int unsigned count);
    if (cur + 1 >= count) return 0;
    return cur + 1;
  endfunction

  // true when a counter value is the last one before wrap
  function automatic logic is_last(input int unsigned cur,
                                   input int unsigned count);
    return (cur == count - 1);
  endfunction

endpackage

// File: rtl/pas_tick_gate.sv
module pas_tick_gate
  import pas_pkg::*;
#(
  parameter int unsigned TICKS_PER_CONV = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pacer_tick,
  input  logic ext_enable,
  input  logic pacer_en,
  input  logic sw_trig_mode,
  input  logic sw_start,
  output logic gated_tick,
  output logic conv_req
);

  localparam int unsigned CNT_W = (TICKS_PER_CONV > 1) ? $clog2(TICKS_PER_CONV) : 1;

  logic [CNT_W-1:0] cnt_q;
  logic             burst_q;
  logic             mode_q;
  logic             conv_q;
  logic             clear_cnt;
  logic             window_open;
  logic             at_last;
  logic             open_burst;

  assign clear_cnt   = !pacer_en || (sw_trig_mode != mode_q);
  assign window_open = !sw_trig_mode || burst_q;
  assign gated_tick  = pacer_tick && pacer_en && ext_enable && window_open && !clear_cnt;
  assign at_last     = is_last(int'(cnt_q), TICKS_PER_CONV);
  assign open_burst  = sw_start && sw_trig_mode && !burst_q;
  assign conv_req    = conv_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      burst_q <= 1'b0;
      mode_q  <= 1'b0;
      conv_q  <= 1'b0;
    end else begin
      mode_q <= sw_trig_mode;
      conv_q <= gated_tick && at_last;
      if (clear_cnt) begin
        cnt_q   <= '0;
        burst_q <= 1'b0;
      end else begin
        if (gated_tick) begin
          cnt_q <= CNT_W'(next_index(int'(cnt_q), TICKS_PER_CONV));
          if (at_last) burst_q <= 1'b0;
        end
        if (open_burst) burst_q <= 1'b1;
      end
    end
  end

  // R1: a request follows only a counted tick
  a_r1_req_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req |-> $past(gated_tick));

  // R4: with the pacer disabled no request can follow
  a_r4_off_no_req: assert property (@(posedge clk) disable iff (!rst_n)
    (!pacer_en && !conv_req) |=> !conv_req);

  // R2: triggered mode without an open window counts nothing
  a_r2_closed_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_trig_mode && !burst_q) |-> !gated_tick);

  // R11: a mode change leaves the counter cleared
  a_r11_mode_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_trig_mode != mode_q) |=> (cnt_q == '0));

endmodule

// File: rtl/pas_conv_ctl.sv
module pas_conv_ctl
  import pas_pkg::*;
#(
  parameter int unsigned DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              conv_req,
  input  logic              rd_result,
  input  logic              rd_status,
  input  logic              adc_busy,
  input  logic              adc_done,
  input  logic [DATA_W-1:0] adc_data,
  output logic              adc_start,
  output logic [DATA_W-1:0] result,
  output logic              data_ready_n,
  output logic              irq,
  output logic              overrun,
  output logic              consumed
);

  conv_state_e       st_q;
  logic              capture;
  logic [DATA_W-1:0] result_q;
  logic              drdy_n_q;
  logic              irq_q;
  logic              ovr_q;

  assign adc_start    = (st_q == CV_START);
  assign capture      = (st_q == CV_WAIT) && adc_done;
  assign consumed     = rd_result && !drdy_n_q;
  assign result       = result_q;
  assign data_ready_n = drdy_n_q;
  assign irq          = irq_q;
  assign overrun      = ovr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= CV_IDLE;
      result_q <= '0;
      drdy_n_q <= 1'b1;
      irq_q    <= 1'b0;
      ovr_q    <= 1'b0;
    end else begin
      irq_q <= capture;
      unique case (st_q)
        CV_IDLE:  if (conv_req) st_q <= CV_START;
        CV_START: if (adc_busy) st_q <= CV_WAIT;
        CV_WAIT:  if (adc_done) st_q <= CV_IDLE;
        default:  st_q <= CV_IDLE;
      endcase
      if (capture) begin
        result_q <= adc_data;
        drdy_n_q <= 1'b0;
      end else if (rd_result) begin
        drdy_n_q <= 1'b1;
      end
      if (capture && !drdy_n_q && !rd_result) ovr_q <= 1'b1;
      else if (rd_status)                     ovr_q <= 1'b0;
    end
  end

  // R6: the start request holds until the converter answers busy
  a_r6_start_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (adc_start && !adc_busy) |=> adc_start);

  // R6: the captured value appears on the result port
  a_r6_capture_value: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> (result == $past(adc_data)));

  // R7: the interrupt pulse coincides with a low ready flag
  a_r7_irq_flag: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !data_ready_n);

  // R7: a read without a capture releases the flag
  a_r7_read_release: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_result && !capture) |=> data_ready_n);

  // R8: overrun is sticky until a status read
  a_r8_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !rd_status) |=> overrun);

endmodule

// File: rtl/pas_chan_scan.sv
module pas_chan_scan
  import pas_pkg::*;
#(
  parameter int unsigned NUM_CH = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          autoscan,
  input  logic [$clog2(NUM_CH)-1:0]     sel,
  input  logic                          step,
  output logic [$clog2(NUM_CH)-1:0]     chan
);

  localparam int unsigned CH_W = $clog2(NUM_CH);

  logic [CH_W-1:0] scan_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scan_q <= '0;
    end else if (!autoscan) begin
      scan_q <= sel;
    end else if (step) begin
      scan_q <= CH_W'(next_index(int'(scan_q), NUM_CH));
    end
  end

  assign chan = autoscan ? scan_q : sel;

  // R9: a consuming read moves the channel on by one, wrapping at the top
  a_r9_step_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (autoscan && step) |=> (!autoscan ||
      chan == CH_W'(next_index(int'($past(chan)), NUM_CH))));

  // R10: auto-scan starts from the manually selected channel
  a_r10_entry: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(autoscan) |-> (chan == $past(sel)));

endmodule

// File: rtl/paced_adc_sequencer.sv
module paced_adc_sequencer
  import pas_pkg::*;
#(
  parameter int unsigned TICKS_PER_CONV = 8,
  parameter int unsigned NUM_CH         = 8,
  parameter int unsigned DATA_W         = 12
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      pacer_tick,
  input  logic                      sw_start,
  input  logic                      ext_enable,
  input  logic                      cfg_sw_trig,
  input  logic                      cfg_autoscan,
  input  logic                      cfg_pacer_en,
  input  logic [$clog2(NUM_CH)-1:0] cfg_chan_sel,
  input  logic                      rd_result,
  input  logic                      rd_status,
  input  logic                      adc_busy,
  input  logic                      adc_done,
  input  logic [DATA_W-1:0]         adc_data,
  output logic                      adc_start,
  output logic [$clog2(NUM_CH)-1:0] chan,
  output logic [DATA_W-1:0]         result,
  output logic                      data_ready_n,
  output logic                      irq,
  output logic                      overrun
);

  logic gated_tick;
  logic conv_req;
  logic consumed;

  pas_tick_gate #(.TICKS_PER_CONV(TICKS_PER_CONV)) u_gate (
    .clk          (clk),
    .rst_n        (rst_n),
    .pacer_tick   (pacer_tick),
    .ext_enable   (ext_enable),
    .pacer_en     (cfg_pacer_en),
    .sw_trig_mode (cfg_sw_trig),
    .sw_start     (sw_start),
    .gated_tick   (gated_tick),
    .conv_req     (conv_req)
  );

  pas_conv_ctl #(.DATA_W(DATA_W)) u_conv (
    .clk          (clk),
    .rst_n        (rst_n),
    .conv_req     (conv_req),
    .rd_result    (rd_result),
    .rd_status    (rd_status),
    .adc_busy     (adc_busy),
    .adc_done     (adc_done),
    .adc_data     (adc_data),
    .adc_start    (adc_start),
    .result       (result),
    .data_ready_n (data_ready_n),
    .irq          (irq),
    .overrun      (overrun),
    .consumed     (consumed)
  );

  pas_chan_scan #(.NUM_CH(NUM_CH)) u_scan (
    .clk      (clk),
    .rst_n    (rst_n),
    .autoscan (cfg_autoscan),
    .sel      (cfg_chan_sel),
    .step     (consumed),
    .chan     (chan)
  );

  // R5: with the external pin low no request follows
  a_r5_ext_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_enable && pacer_tick) |-> !gated_tick);

endmodule

// File: tb/paced_adc_sequencer_tb.sv
module paced_adc_sequencer_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pacer_tick = 0, sw_start = 0, ext_enable = 1;
  logic        cfg_sw_trig = 0, cfg_autoscan = 0, cfg_pacer_en = 1;
  logic [2:0]  cfg_chan_sel = 3'd0;
  logic        rd_result = 0, rd_status = 0;
  logic        adc_busy = 0, adc_done = 0;
  logic [11:0] adc_data = 12'h0;
  logic        adc_start;
  logic [2:0]  chan;
  logic [11:0] result;
  logic        data_ready_n, irq, overrun;

  int total = 0, bad = 0, cycles = 0, irq_seen = 0;
  bit auto_rd = 0, finished = 0;

  always #10 clk = ~clk;

  paced_adc_sequencer u_dut (
    .clk(clk), .rst_n(rst_n), .pacer_tick(pacer_tick), .sw_start(sw_start),
    .ext_enable(ext_enable), .cfg_sw_trig(cfg_sw_trig), .cfg_autoscan(cfg_autoscan),
    .cfg_pacer_en(cfg_pacer_en), .cfg_chan_sel(cfg_chan_sel), .rd_result(rd_result),
    .rd_status(rd_status), .adc_busy(adc_busy), .adc_done(adc_done), .adc_data(adc_data),
    .adc_start(adc_start), .chan(chan), .result(result), .data_ready_n(data_ready_n),
    .irq(irq), .overrun(overrun)
  );

  // converter model: answers busy one cycle after start, done four cycles later
  int          a_left = 0;
  logic [11:0] a_next = 12'h123;
  logic [11:0] a_last = 12'h000;
  always @(posedge clk) begin
    adc_done <= 1'b0;
    if (adc_busy) begin
      if (a_left == 1) begin
        adc_busy <= 1'b0; adc_done <= 1'b1; adc_data <= a_next;
        a_last   <= a_next; a_next <= a_next + 12'h1A7;
      end
      a_left <= a_left - 1;
    end else if (adc_start && !adc_done) begin
      adc_busy <= 1'b1; a_left <= 4;
    end
  end

  // behavioural reference model
  int   m_cnt = 0, m_phase = 0, m_scan = 0;
  bit   m_burst = 0, m_mode = 0, m_req = 0, m_drdy = 1, m_irq = 0, m_ovr = 0;
  logic [11:0] m_res = 0;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_phase = 0; m_scan = 0; m_burst = 0; m_mode = 0;
      m_req = 0; m_drdy = 1; m_irq = 0; m_ovr = 0; m_res = 0;
    end else begin
      bit admit, new_req, cap, old_drdy;
      old_drdy = m_drdy;
      new_req  = 0;
      if (!cfg_pacer_en || (cfg_sw_trig != m_mode)) begin
        m_cnt = 0; m_burst = 0;
      end else begin
        admit = pacer_tick && ext_enable && (!cfg_sw_trig || m_burst);
        if (admit) begin
          m_cnt = m_cnt + 1;
          if (m_cnt == 8) begin m_cnt = 0; new_req = 1; m_burst = 0; end
        end else if (sw_start && cfg_sw_trig && !m_burst) m_burst = 1;
      end
      m_mode = cfg_sw_trig;
      cap = (m_phase == 2) && adc_done;
      if (cap) begin
        if (!old_drdy && !rd_result) m_ovr = 1;
        m_res = adc_data; m_drdy = 0;
      end else if (rd_result) m_drdy = 1;
      if (!(cap && !old_drdy && !rd_result) && rd_status) m_ovr = 0;
      m_irq = cap;
      if (!cfg_autoscan) m_scan = cfg_chan_sel;
      else if (rd_result && !old_drdy) m_scan = (m_scan + 1) % 8;
      case (m_phase)
        0: if (m_req) m_phase = 1;
        1: if (adc_busy) m_phase = 2;
        default: if (adc_done) m_phase = 0;
      endcase
      m_req = new_req;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    #1;
    if (rst_n && !finished) begin
      int exp_ch;
      exp_ch = cfg_autoscan ? m_scan : cfg_chan_sel;
      chk("R6 adc_start per-cycle", adc_start, (m_phase == 1));
      chk("R6 result per-cycle", result, m_res);
      chk("R7 data_ready_n per-cycle", data_ready_n, m_drdy);
      chk("R7 irq per-cycle", irq, m_irq);
      chk("R8 overrun per-cycle", overrun, m_ovr);
      chk("R9 R10 chan per-cycle", chan, exp_ch);
      if (irq) irq_seen++;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000 && !finished) begin
      finished = 1; bad++; total++;
      $display("FAIL watchdog actual=%0d expected=<50000", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic cyc(input bit tick, input bit start, input bit stat);
    @(negedge clk);
    pacer_tick = tick; sw_start = start; rd_status = stat;
    rd_result  = auto_rd && !data_ready_n;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      cyc(1, 0, 0); cyc(0, 0, 0); cyc(0, 0, 0); cyc(0, 0, 0);
    end
  endtask

  task automatic drain();
    for (int i = 0; i < 20; i++) cyc(0, 0, 0);
  endtask

  initial begin
    int base;
    repeat (3) @(negedge clk);
    #2;
    chk("R7 reset data_ready_n", data_ready_n, 1);
    chk("R7 reset irq", irq, 0);
    chk("R7 reset overrun", overrun, 0);
    chk("R7 reset result", result, 0);
    chk("R7 reset adc_start", adc_start, 0);
    @(negedge clk); rst_n = 1;

    // R1 free-running: 80 ticks give 10 results
    auto_rd = 1; base = irq_seen;
    ticks(80); drain();
    chk("R1 free-running result count", irq_seen - base, 10);
    chk("R8 no overrun with prompt reads", overrun, 0);
    chk("R6 result equals last converter value", result, a_last);

    // R2 triggered mode with no start
    cfg_sw_trig = 1; cyc(0, 0, 0); cyc(0, 0, 0);
    base = irq_seen; ticks(40); drain();
    chk("R2 no conversion without start", irq_seen - base, 0);

    // R3 one burst, second start ignored
    base = irq_seen;
    cyc(0, 1, 0); ticks(3); cyc(0, 1, 0); ticks(21); drain();
    chk("R3 one result per start", irq_seen - base, 1);

    // R4 pacer disabled, then counter starts from zero
    cfg_sw_trig = 0; cyc(0, 0, 0); cyc(0, 0, 0);
    base = irq_seen; ticks(5); cfg_pacer_en = 0; ticks(16); drain();
    chk("R4 pacer off blocks", irq_seen - base, 0);
    cfg_pacer_en = 1; ticks(7); drain();
    chk("R4 counter cleared by disable", irq_seen - base, 0);
    ticks(1); drain();
    chk("R4 eighth tick after re-enable", irq_seen - base, 1);

    // R5 external pin holds the counter
    base = irq_seen; ticks(4); ext_enable = 0; ticks(16); ext_enable = 1; ticks(3); drain();
    chk("R5 pin low blocks ticks", irq_seen - base, 0);
    ticks(1); drain();
    chk("R5 count resumes after pin high", irq_seen - base, 1);

    // R8 overrun set and cleared
    auto_rd = 0; ticks(16); drain();
    chk("R8 overrun set", overrun, 1);
    chk("R7 flag low while unread", data_ready_n, 0);
    cyc(0, 0, 1); cyc(0, 0, 0); #2;
    chk("R8 status read clears", overrun, 0);
    auto_rd = 1; cyc(0, 0, 0); cyc(0, 0, 0); #2;
    chk("R7 read releases flag", data_ready_n, 1);

    // R10 manual select, then R9 scanning with wrap
    cfg_chan_sel = 3'd6; cyc(0, 0, 0); #2;
    chk("R10 manual channel", chan, 6);
    cfg_autoscan = 1; cyc(0, 0, 0); #2;
    chk("R10 scan starts at selected", chan, 6);
    ticks(24); drain();
    chk("R9 three reads wrap 6 to 1", chan, 1);
    cfg_autoscan = 0; cfg_chan_sel = 3'd2; cyc(0, 0, 0); #2;
    chk("R10 manual again", chan, 2);

    // R11 mode flip clears the counter
    base = irq_seen; ticks(5);
    cfg_sw_trig = 1; cyc(0, 0, 0); cfg_sw_trig = 0; cyc(0, 0, 0); cyc(0, 0, 0);
    ticks(7); drain();
    chk("R11 mode flip clears count", irq_seen - base, 0);
    ticks(1); drain();
    chk("R11 eighth tick after flip", irq_seen - base, 1);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule